// File: doc/BRIEF.md
# Dual-Channel PWM Counter Slice

This block is one pulse-width modulation slice. A 16-bit counter steps once in each cycle where an external clock-enable strobe is high and the slice is switched on. Two compare channels, A and B, watch the counter. Each channel drives its output high while its compare value is strictly larger than the count. Each channel can also be inverted.

The counter has two modes. In the edge-aligned mode it climbs from zero to a programmable top value and then restarts at zero. In the centred (phase-correct) mode it climbs to top, stays there for one step while it turns round, and then descends to zero. At zero it stays for one step, turns round again and climbs. This gives symmetric pulses at half the repetition rate.

A sticky wrap flag marks the end of each period, and software clears it by writing a one. Software reaches the slice through a simple write port. That port carries the control bits, the top value, the two compare values, a direct write to the counter, and the flag clear. Top and compare writes are held in shadow registers. They move into the active copies at the next wrap, or at once while the slice is stopped.

Top module: `pwm_slice`

## Requirements
- R1: Each channel output, before inversion, is high exactly while the active compare value of that channel is strictly greater than the current counter value.
- R2: An active compare of 0 keeps the un-inverted output low for the whole period, and an active compare of top+1 keeps it high for the whole period.
- R3: With control bit 1 clear (edge-aligned), the counter visits 0,1,...,top and then returns to 0, so the period is top+1 steps; the wrap happens on the step taken from top.
- R4: With control bit 1 set (centred), the counter visits 0..top, holds top for one step while the direction turns to down, descends to 0, then holds 0 for one step while turning back up; the period is 2*(top+1) steps and the wrap happens on the step taken from 0 while descending.
- R5: Control bit 2 inverts output A and control bit 3 inverts output B, each applied after the compare.
- R6: Reset clears the counter to 0, the direction to up, the wrap flag to 0 and all control bits. A write to address 4 loads the counter with the written value on that edge and sets the direction to up, taking priority over counting.
- R7: The wrap flag is set by every wrap and stays set. A write to address 5 with data bit 0 set clears it, while data bit 0 clear leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: While control bit 0 (enable) is clear, the counter and direction hold their values.
- R9: The counter steps only in cycles where the tick input is high.
- R10: Writes to top (address 1), compare A (address 2) and compare B (address 3) take effect at the next wrap while the slice runs, and within one cycle while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-enable strobe from the external divider |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Write address: 0 control, 1 top, 2 compare A, 3 compare B, 4 counter, 5 flag clear |
| cfg_wdata | input | W | Write data; control bits are 0 enable, 1 centred mode, 2 invert A, 3 invert B |
| cnt_o | output | W | Current counter value |
| dir_down | output | 1 | Counting direction, 1 while descending |
| out_a | output | 1 | Channel A output |
| out_b | output | 1 | Channel B output |
| wrap_flag | output | 1 | Sticky wrap flag |

## Verification
The bench sweeps every compare value from 0 to top+1 for small top values, including top of 0, in both counting modes and with the inversion bits mixed in. It predicts count, outputs and flag from the step number alone. A slice that compared with greater-or-equal would show a one-step high pulse at compare 0, and an off-by-one at the turnarounds would stretch or shorten the centred period or fire the flag at the top instead of at zero. A mid-period change of top and compare checks that the old top still ends the period; a design without shadow registers would switch at once or run past the new top. The directed checks hold the tick low, clear the enable, write the counter and clear the flag with and without data bit 0. These catch counters that drift while gated and flags that are not sticky.

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cfg_wr,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cnt_o,
  output logic         dir_down,
  output logic         out_a,
  output logic         out_b,
  output logic         wrap_flag
);
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_TOP  = 3'd1;
  localparam logic [2:0] ADR_CMPA = 3'd2;
  localparam logic [2:0] ADR_CMPB = 3'd3;
  localparam logic [2:0] ADR_CNT  = 3'd4;
  localparam logic [2:0] ADR_CLR  = 3'd5;

  logic         en_r, ph_r, inv_a_r, inv_b_r;
  logic [W-1:0] top_s, cmpa_s, cmpb_s;
  logic [W-1:0] top_q, cmpa_q, cmpb_q;
  logic [W-1:0] cnt;

  wire wr_ctrl = cfg_wr && (cfg_addr == ADR_CTRL);
  wire wr_cnt  = cfg_wr && (cfg_addr == ADR_CNT);
  wire wr_clr  = cfg_wr && (cfg_addr == ADR_CLR) && cfg_wdata[0];
  wire step    = en_r && tick;
  wire at_top  = (cnt == top_q);
  wire at_zero = (cnt == '0);
  wire wrap_ev = step && !wr_cnt && (ph_r ? (dir_down && at_zero) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r <= 1'b0; ph_r <= 1'b0; inv_a_r <= 1'b0; inv_b_r <= 1'b0;
      top_s <= '1; cmpa_s <= '0; cmpb_s <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        ADR_CTRL: begin
          en_r    <= cfg_wdata[0];
          ph_r    <= cfg_wdata[1];
          inv_a_r <= cfg_wdata[2];
          inv_b_r <= cfg_wdata[3];
        end
        ADR_TOP:  top_s  <= cfg_wdata;
        ADR_CMPA: cmpa_s <= cfg_wdata;
        ADR_CMPB: cmpb_s <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '1; cmpa_q <= '0; cmpb_q <= '0;
    end else if (!en_r || wrap_ev) begin
      top_q <= top_s; cmpa_q <= cmpa_s; cmpb_q <= cmpb_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dir_down <= 1'b0;
    end else if (wr_cnt) begin
      cnt <= cfg_wdata;
      dir_down <= 1'b0;
    end else if (step) begin
      if (!ph_r) begin
        cnt <= at_top ? '0 : cnt + 1'b1;
        dir_down <= 1'b0;
      end else if (!dir_down) begin
        if (at_top) dir_down <= 1'b1;
        else        cnt <= cnt + 1'b1;
      end else begin
        if (at_zero) dir_down <= 1'b0;
        else         cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wrap_flag <= 1'b0;
    else if (wrap_ev) wrap_flag <= 1'b1;
    else if (wr_clr)  wrap_flag <= 1'b0;
  end

  assign cnt_o = cnt;
  assign out_a = (cmpa_q > cnt) ^ inv_a_r;
  assign out_b = (cmpb_q > cnt) ^ inv_b_r;
endmodule

module pwm_slice_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cfg_wr,
  input logic [2:0]   cfg_addr,
  input logic [W-1:0] cfg_wdata,
  input logic [W-1:0] cnt,
  input logic         dir_down,
  input logic         en,
  input logic         ph,
  input logic         inv_a,
  input logic [W-1:0] top_act,
  input logic [W-1:0] cmpa_act,
  input logic         out_a,
  input logic         flag
);
  wire cnt_wr = cfg_wr && (cfg_addr == 3'd4);
  wire clr_wr = cfg_wr && (cfg_addr == 3'd5) && cfg_wdata[0];

  assert_tick_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> ($stable(cnt) && $stable(dir_down)));

  assert_edge_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !ph && !cnt_wr && cnt == top_act) |=> (cnt == '0));

  assert_top_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && ph && !dir_down && !cnt_wr && cnt == top_act) |=> (dir_down && $stable(cnt)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);

  assert_zero_cmp_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_act == '0) |-> (out_a == inv_a));
endmodule

bind pwm_slice pwm_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cnt(cnt), .dir_down(dir_down), .en(en_r), .ph(ph_r),
  .inv_a(inv_a_r), .top_act(top_q), .cmpa_act(cmpa_q), .out_a(out_a), .flag(wrap_flag)
);

// File: tb/test_pwm_slice.sv
module test_pwm_slice;
  localparam int W = 16;
  localparam time CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b1;
  logic         cfg_wr = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] cnt_o;
  logic         dir_down, out_a, out_b, wrap_flag;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PER/2) clk = ~clk;

  pwm_slice #(.W(W)) i_pwm_slice (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cnt_o(cnt_o), .dir_down(dir_down), .out_a(out_a),
    .out_b(out_b), .wrap_flag(wrap_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    cfg_wr = 1'b1; cfg_addr = 3'(addr); cfg_wdata = W'(data);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic setup(input int top, input int ca, input int cb, input int ctrl);
    wr(0, 0);
    wr(1, top);
    wr(2, ca);
    wr(3, cb);
    wr(4, 0);
    wr(5, 1);
    wr(0, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(cnt_o == 0, "R6 reset count", int'(cnt_o), 0);
    check(wrap_flag == 0, "R6 reset flag", int'(wrap_flag), 0);
    check(out_a == 0 && out_b == 0, "R6 reset outputs", int'({out_a, out_b}), 0);

    // Sweep: R1 R2 R3 R4 R5 R7 R10 (disabled load is immediate)
    for (int ph = 0; ph < 2; ph++) begin
      for (int top = 0; top < 6; top++) begin
        for (int c = 0; c <= top + 1; c++) begin
          int ia, ib, per, p, ec, cb;
          ia = top % 2; ib = 1 - ia; cb = top + 1 - c;
          per = ph ? 2 * (top + 1) : top + 1;
          setup(top, c, cb, 1 | (ph << 1) | (ia << 2) | (ib << 3));
          for (int n = 0; n < 2 * per + 1; n++) begin
            p = n % per;
            ec = (ph == 0 || p <= top) ? p : 2 * top + 1 - p;
            check(int'(cnt_o) == ec, ph ? "R4 centred count" : "R3 edge count", int'(cnt_o), ec);
            check(out_a == ((c > ec) ^ ia[0]), "R1 R2 R5 out_a", int'(out_a), int'((c > ec) ^ ia[0]));
            check(out_b == ((cb > ec) ^ ib[0]), "R1 R2 R5 out_b", int'(out_b), int'((cb > ec) ^ ib[0]));
            check(wrap_flag == (n >= per), "R7 wrap flag", int'(wrap_flag), int'(n >= per));
            @(negedge clk);
          end
        end
      end
    end

    // R7 clear behaviour
    wr(5, 2);
    check(wrap_flag == 1, "R7 clear ignored without bit0", int'(wrap_flag), 1);
    setup(9, 5, 0, 1);
    repeat (12) @(negedge clk);
    check(wrap_flag == 1, "R7 flag set", int'(wrap_flag), 1);
    wr(5, 1);
    check(wrap_flag == 0, "R7 flag cleared", int'(wrap_flag), 0);

    // R6 direct counter write
    wr(4, 7);
    check(cnt_o == 7, "R6 counter write", int'(cnt_o), 7);
    @(negedge clk);
    check(cnt_o == 8, "R6 counts on from write", int'(cnt_o), 8);

    // R9 tick gating
    tick = 1'b0;
    held = int'(cnt_o);
    repeat (5) @(negedge clk);
    check(int'(cnt_o) == held, "R9 no tick holds", int'(cnt_o), held);
    wr(4, 0);
    for (int k = 0; k < 6; k++) begin
      tick = k[0];
      @(negedge clk);
    end
    tick = 1'b1;
    check(cnt_o == 3, "R9 alternating ticks", int'(cnt_o), 3);

    // R8 enable gating
    wr(0, 0);
    held = int'(cnt_o);
    repeat (5) @(negedge clk);
    check(int'(cnt_o) == held, "R8 disabled holds", int'(cnt_o), held);

    // R10 shadowed top/compare while running
    setup(9, 5, 0, 1);
    repeat (5) @(negedge clk);
    check(cnt_o == 5, "R10 pre", int'(cnt_o), 5);
    wr(1, 3);
    wr(2, 8);
    check(cnt_o == 7 && out_a == 0, "R10 old compare held", int'(out_a), 0);
    repeat (2) @(negedge clk);
    check(cnt_o == 9, "R10 old top held", int'(cnt_o), 9);
    @(negedge clk);
    check(cnt_o == 0 && out_a == 1, "R10 new compare at wrap", int'(out_a), 1);
    repeat (4) @(negedge clk);
    check(cnt_o == 0, "R10 new top in force", int'(cnt_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule